// File: doc/BRIEF.md
# Power-Management Event Status Controller

This block keeps a small set of sticky status flags for power-management events. It watches three active-low board inputs: a power-management event line, a battery-low line and a ring-indicate line. It also watches in-band event messages that arrive from a configurable number of serial links. Hardware sets a flag when its event occurs. Software clears a flag by writing a 1 to its position. Each flag has an enable bit, and a single control bit selects between the system-control interrupt (SCI) and the system-management interrupt (SMI).

The current sleep state and a flag telling whether an S5 entry was forced decide what a pending, enabled event does. In the working state it raises an SCI or an SMI. In a light or software-entered sleep state it requests a wake and also raises an SCI. In a forced-off state it does nothing. The SCI is a level output. It stays high as long as any flag and its enable are both set.

The link-event flag has an interlock. Once a link has signalled an asserted general-purpose event, software cannot clear that flag until the matching release message has arrived.

Top module: `pme_stat_ctrl`

## Requirements
- R1: After reset, the status, enable and control registers read 0, and `sci`, `smi` and `wake` are low.
- R2: Register map: address 0 is status, address 1 is enable and address 2 is control (bit 0 set selects SCI routing). Address 3 reads 0. The status bits are: bit 0 power event, bit 1 battery low, bit 2 ring, bit 3 link event. Writing 1 to a status bit clears it in the next cycle. Writing 0 leaves it unchanged.
- R3: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Status bit 0 sets once for each high-to-low transition of `pme_n`, SYNC_STAGES+1 clock edges after the change is sampled. If the line is held low after a clear, the bit is not set again.
- R5: Status bit 1 is set on every cycle in which the synchronised `batlow_n` is low, so a clear does not hold while the line stays low.
- R6: Status bit 2 sets on each high-to-low transition of `ring_n`, with the same timing as bit 0.
- R7: Status bit 3 sets in the cycle after any bit of `link_pme_msg` is high, or after `gpe_assert_msg` is high.
- R8: After `gpe_assert_msg`, a write-1 clear of bit 3 has no effect until a cycle with `gpe_deassert_msg` high has passed. A clear in that same deassert cycle is still blocked.
- R9: With `sleep_state` 0 (working) and a pending enabled flag, `sci` is high if control bit 0 is 1, and `smi` is high if it is 0.
- R10: With `sleep_state` 1 to 4, or 5 with `s5_forced` low, a pending enabled flag drives both `wake` and `sci` high and `smi` low.
- R11: With `sleep_state` 5 and `s5_forced` high, or with codes 6 and 7, `sci`, `smi` and `wake` all stay low.
- R12: `sci` is a level. It stays high while any flag and its enable are both set. It falls as soon as the last such pair is broken, either by a clear or by a write to the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| pme_n | input | 1 | Power-management event line, active low, asynchronous |
| batlow_n | input | 1 | Battery-low line, active low, asynchronous |
| ring_n | input | 1 | Ring-indicate line, active low, asynchronous |
| link_pme_msg | input | NUM_LINKS | One-cycle event-message pulses, one per link |
| gpe_assert_msg | input | 1 | General-purpose event asserted message pulse |
| gpe_deassert_msg | input | 1 | General-purpose event released message pulse |
| sleep_state | input | 3 | Current sleep state code, 0 to 5 |
| s5_forced | input | 1 | S5 entered through override or power loss |
| sci | output | 1 | Level system-control interrupt |
| smi | output | 1 | System-management interrupt request |
| wake | output | 1 | Wake request |

## Verification
The bench builds the block with SYNC_STAGES=2 and NUM_LINKS=3. These values make the synchroniser latency a real, measurable delay, and they let individual link messages be told apart from the OR across links. A behavioural reference model replays every input through a queue as deep as the synchroniser and predicts the status bits and all three outputs on each cycle. It can therefore catch a latency off by one edge, a re-triggering edge detector or a broken clear interlock, and it does so under all six sleep codes plus the two reserved ones.

// File: rtl/pme_pkg.sv
package pme_pkg;
   localparam int NUM_EVT   = 4;
   localparam int EVT_PME   = 0;
   localparam int EVT_BAT   = 1;
   localparam int EVT_RING  = 2;
   localparam int EVT_LINK  = 3;

   localparam int ADDR_W    = 2;
   localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
   localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

   typedef enum logic [2:0] {
      SL_WORK  = 3'd0,
      SL_S1    = 3'd1,
      SL_S2    = 3'd2,
      SL_S3    = 3'd3,
      SL_S4    = 3'd4,
      SL_OFF   = 3'd5,
      SL_RSV6  = 3'd6,
      SL_RSV7  = 3'd7
   } sleep_e;
endpackage

// File: rtl/pme_in_sense.sv
module pme_in_sense #(
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_MODE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic hit
);
   logic synced_n;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced_n = pin_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else if (SYNC_STAGES == 1) chain <= pin_n;
            else chain <= {chain[SYNC_STAGES-2:0], pin_n} ;
         end
         assign synced_n = chain[SYNC_STAGES-1];
      end
   endgenerate

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_n;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_n <= 1'b1;
            else        prev_n <= synced_n;
         end
         assign hit = prev_n & ~synced_n;

         // R4
         edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> !hit);
      end else begin : g_level
         assign hit = ~synced_n;
      end
   endgenerate
endmodule

// File: rtl/pme_w1c_bit.sv
module pme_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic hold_i,
   output logic q_o
);
   logic clr_ok;
   assign clr_ok = clr_i & ~hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_ok) q_o <= 1'b0;
   end

   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R2
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i && !hold_i) |=> !q_o);
   // R8
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && q_o && !set_i) |=> q_o);
   // R2
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_o && !set_i) |=> !q_o);
endmodule

// File: rtl/pme_router.sv
module pme_router
   import pme_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sleep_i,
   input  logic       forced_i,
   input  logic       route_sci_i,
   input  logic       pending_i,
   output logic       sci_o,
   output logic       smi_o,
   output logic       wake_o
);
   sleep_e st;
   logic   working, asleep;

   always_comb begin
      st      = sleep_e'(sleep_i);
      working = 1'b0;
      asleep  = 1'b0;
      unique case (st)
         SL_WORK:                    working = 1'b1;
         SL_S1, SL_S2, SL_S3, SL_S4: asleep  = 1'b1;
         SL_OFF:                     asleep  = ~forced_i;
         default: ;
      endcase
   end

   always_comb begin
      sci_o  = pending_i & ((working & route_sci_i) | asleep);
      smi_o  = pending_i & working & ~route_sci_i;
      wake_o = pending_i & asleep;
   end

   // R9
   sci_smi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sci_o && smi_o));
   // R11
   forced_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i == 3'd5 && forced_i) |-> !(sci_o || smi_o || wake_o));
   // R10
   wake_with_sci_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (sci_o && !smi_o));
endmodule

// File: rtl/pme_stat_ctrl.sv
module pme_stat_ctrl
   import pme_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NUM_LINKS   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 pme_n,
   input  logic                 batlow_n,
   input  logic                 ring_n,
   input  logic [NUM_LINKS-1:0] link_pme_msg,
   input  logic                 gpe_assert_msg,
   input  logic                 gpe_deassert_msg,
   input  logic [2:0]           sleep_state,
   input  logic                 s5_forced,
   output logic                 sci,
   output logic                 smi,
   output logic                 wake
);
   localparam int PAD_W = DATA_W - NUM_EVT;

   generate
      if (DATA_W < NUM_EVT) begin : g_bad_w
         $error("DATA_W must hold all status bits");
      end
      if (NUM_LINKS < 1) begin : g_bad_links
         $error("NUM_LINKS must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic [NUM_EVT-1:0] set_v, clr_v, hold_v, stat_q;
   logic [NUM_EVT-1:0] en_q;
   logic               route_q, gpe_hold_q, pending;
   logic               wr_stat, wr_en_reg, wr_ctrl;

   assign wr_stat   = wr_en && (wr_addr == A_STATUS);
   assign wr_en_reg = wr_en && (wr_addr == A_ENABLE);
   assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);

   pme_in_sense #(.SYNC_STAGES(SYNC_STAGES), .EDGE_MODE(1'b1)) u_pme (
      .clk(clk), .rst_n(rst_n), .pin_n(pme_n), .hit(set_v[EVT_PME]));
   pme_in_sense #(.SYNC_STAGES(SYNC_STAGES), .EDGE_MODE(1'b0)) u_bat (
      .clk(clk), .rst_n(rst_n), .pin_n(batlow_n), .hit(set_v[EVT_BAT]));
   pme_in_sense #(.SYNC_STAGES(SYNC_STAGES), .EDGE_MODE(1'b1)) u_ring (
      .clk(clk), .rst_n(rst_n), .pin_n(ring_n), .hit(set_v[EVT_RING]));

   assign set_v[EVT_LINK] = (|link_pme_msg) | gpe_assert_msg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gpe_hold_q <= 1'b0;
      else if (gpe_assert_msg)   gpe_hold_q <= 1'b1;
      else if (gpe_deassert_msg) gpe_hold_q <= 1'b0;
   end

   always_comb begin
      hold_v           = '0;
      hold_v[EVT_LINK] = gpe_hold_q;
      clr_v            = wr_stat ? wr_data[NUM_EVT-1:0] : '0;
   end

   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
         pme_w1c_bit u_bit (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .clr_i(clr_v[i]),
            .hold_i(hold_v[i]), .q_o(stat_q[i]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         route_q <= 1'b0;
      end else begin
         if (wr_en_reg) en_q    <= wr_data[NUM_EVT-1:0];
         if (wr_ctrl)   route_q <= wr_data[0];
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_STATUS: rd_data[NUM_EVT-1:0] = stat_q;
         A_ENABLE: rd_data[NUM_EVT-1:0] = en_q;
         A_CTRL:   rd_data[0]           = route_q;
         default:  rd_data              = '0;
      endcase
   end

   assign pending = |(stat_q & en_q);

   pme_router u_route (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_state), .forced_i(s5_forced),
      .route_sci_i(route_q), .pending_i(pending),
      .sci_o(sci), .smi_o(smi), .wake_o(wake));

   // R7
   link_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|link_pme_msg) |=> stat_q[EVT_LINK]);
   // R12
   sci_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sci |-> |(stat_q & en_q));
   // R8
   gpe_hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpe_assert_msg) |=> gpe_hold_q && stat_q[EVT_LINK]);
   // R2
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PAD_W == 0) || (rd_data[DATA_W-1:NUM_EVT] == '0));
endmodule

// File: tb/tb_pme_stat_ctrl.sv
module tb_pme_stat_ctrl;
   localparam int DW = 8, NL = 3, SS = 2;
   localparam time CLK_P = 4ns;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0;
   logic [1:0] wr_addr = 0, rd_addr = 0;
   logic [DW-1:0] wr_data = 0, rd_data;
   logic pme_n = 1, batlow_n = 1, ring_n = 1;
   logic [NL-1:0] link_pme_msg = 0;
   logic gpe_assert_msg = 0, gpe_deassert_msg = 0;
   logic [2:0] sleep_state = 0;
   logic s5_forced = 0;
   logic sci, smi, wake;

   int checks = 0, fails = 0;
   string tag = "R1";
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   pme_stat_ctrl #(.DATA_W(DW), .NUM_LINKS(NL), .SYNC_STAGES(SS)) dut (.*);

   // behavioural reference model
   bit qp[$], qb[$], qr[$];
   bit m_pp, m_rp, m_hold, m_ctrl;
   bit [3:0] m_stat, m_en;

   task automatic model_reset();
      qp = {}; qb = {}; qr = {};
      for (int i = 0; i < SS; i++) begin qp.push_back(1); qb.push_back(1); qr.push_back(1); end
      m_pp = 1; m_rp = 1; m_hold = 0; m_ctrl = 0; m_stat = 0; m_en = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit ps, bs, rs;
         bit [3:0] set, clr;
         ps = (SS == 0) ? pme_n : qp[0];
         bs = (SS == 0) ? batlow_n : qb[0];
         rs = (SS == 0) ? ring_n : qr[0];
         if (SS > 0) begin
            void'(qp.pop_front()); qp.push_back(pme_n);
            void'(qb.pop_front()); qb.push_back(batlow_n);
            void'(qr.pop_front()); qr.push_back(ring_n);
         end
         set = 0;
         if (m_pp && !ps) set[0] = 1;
         m_pp = ps;
         if (!bs) set[1] = 1;
         if (m_rp && !rs) set[2] = 1;
         m_rp = rs;
         if ((|link_pme_msg) || gpe_assert_msg) set[3] = 1;
         clr = (wr_en && wr_addr == 0) ? wr_data[3:0] : 4'd0;
         if (m_hold) clr[3] = 0;
         m_stat = (m_stat & ~clr) | set;
         if (gpe_assert_msg) m_hold = 1;
         else if (gpe_deassert_msg) m_hold = 0;
         if (wr_en && wr_addr == 1) m_en = wr_data[3:0];
         if (wr_en && wr_addr == 2) m_ctrl = wr_data[0];
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      bit pend, esci, esmi, ewake;
      logic [DW-1:0] erd;
      pend = |(m_stat & m_en);
      esci = 0; esmi = 0; ewake = 0;
      if (sleep_state == 0) begin esci = pend & m_ctrl; esmi = pend & ~m_ctrl; end
      else if (sleep_state <= 4 || (sleep_state == 5 && !s5_forced)) begin
         esci = pend; ewake = pend;
      end
      case (rd_addr)
         0: erd = DW'(m_stat);
         1: erd = DW'(m_en);
         2: erd = DW'(m_ctrl);
         default: erd = 0;
      endcase
      check(tag, rd_data, erd, "rd_data");
      check(tag, {sci, smi, wake}, {esci, esmi, ewake}, "sci/smi/wake");
   endtask

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #1; compare(); end
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state at every address
      tag = "R1";
      for (int a = 0; a < 4; a++) begin
         rd_addr = 2'(a); #0.5;
         check("R1", rd_data, 0, "reset register");
      end
      rd_addr = 0;
      check("R1", {sci, smi, wake}, 0, "reset outputs");
      tick(2);

      // R4 power-event edge, latency and no re-trigger while held low
      tag = "R4";
      wr(1, 8'h0F);
      wr(2, 8'h01);
      pme_n = 0;
      tick(SS);
      check("R4", rd_data[0], 0, "bit0 before latency");
      tick();
      check("R4", rd_data[0], 1, "bit0 after latency");
      wr(0, 8'h01);
      tick(4);
      check("R4", rd_data[0], 0, "bit0 stays clear while held low");
      pme_n = 1; tick(4);

      // R2 write 0 no effect, address 3 reads 0
      tag = "R2";
      ring_n = 0; tick(SS + 2); ring_n = 1;
      wr(0, 8'h00);
      check("R2", rd_data[2], 1, "write 0 keeps bit");
      rd_addr = 3; #0.5; check("R2", rd_data, 0, "address 3"); rd_addr = 0;
      wr(0, 8'h04);
      check("R2", rd_data[2], 0, "write 1 clears");

      // R6 ring pulses
      tag = "R6";
      for (int k = 0; k < 2; k++) begin
         ring_n = 0; tick(SS + 1);
         check("R6", rd_data[2], 1, "ring set");
         ring_n = 1; wr(0, 8'h04); tick(3);
      end

      // R5 battery low level keeps re-setting
      tag = "R5";
      batlow_n = 0; tick(SS + 1);
      check("R5", rd_data[1], 1, "batlow set");
      wr(0, 8'h02);
      check("R5", rd_data[1], 1, "batlow re-set while low");
      batlow_n = 1; tick(SS + 1); wr(0, 8'h02);
      check("R5", rd_data[1], 0, "batlow cleared after release");

      // R7 each link, then R3 set beats clear
      tag = "R7";
      for (int p = 0; p < NL; p++) begin
         link_pme_msg = NL'(1) << p; tick(); link_pme_msg = 0;
         check("R7", rd_data[3], 1, "link message sets");
         wr(0, 8'h08);
         check("R7", rd_data[3], 0, "link clear");
      end
      tag = "R3";
      link_pme_msg = 1; wr(0, 8'h08); link_pme_msg = 0;
      check("R3", rd_data[3], 1, "set wins over clear");
      wr(0, 8'h08);

      // R8 interlock
      tag = "R8";
      gpe_assert_msg = 1; tick(); gpe_assert_msg = 0;
      wr(0, 8'h08);
      check("R8", rd_data[3], 1, "clear blocked");
      gpe_deassert_msg = 1; wr(0, 8'h08); gpe_deassert_msg = 0;
      check("R8", rd_data[3], 1, "clear blocked in deassert cycle");
      wr(0, 8'h08);
      check("R8", rd_data[3], 0, "clear after deassert");

      // R9 working state routing
      tag = "R9";
      ring_n = 0; tick(SS + 1); ring_n = 1;
      check("R9", {sci, smi, wake}, 3'b100, "sci route");
      wr(2, 8'h00);
      check("R9", {sci, smi, wake}, 3'b010, "smi route");
      wr(2, 8'h01);

      // R10 sleep states
      tag = "R10";
      for (int s = 1; s <= 5; s++) begin
         sleep_state = 3'(s); tick();
         check("R10", {sci, smi, wake}, 3'b101, "sleep wake");
      end

      // R11 forced off and reserved codes
      tag = "R11";
      s5_forced = 1; tick();
      check("R11", {sci, smi, wake}, 0, "forced S5 quiet");
      s5_forced = 0;
      for (int s = 6; s <= 7; s++) begin
         sleep_state = 3'(s); tick();
         check("R11", {sci, smi, wake}, 0, "reserved code quiet");
      end
      sleep_state = 0; tick();

      // R12 level SCI
      tag = "R12";
      tick(5);
      check("R12", sci, 1, "sci holds");
      wr(1, 8'h0B);
      check("R12", sci, 0, "sci drops on enable off");
      wr(1, 8'h0F);
      check("R12", sci, 1, "sci returns");
      wr(0, 8'h04);
      check("R12", sci, 0, "sci drops on clear");
      tick(3);

      done = 1;
      finish_run();
   end
endmodule